// File: doc/BRIEF.md
# Enable and Soft-Start Sequencer

This block is the digital sequencer of a multiphase buck controller. It watches three kinds of readiness comparator results: the controller bias supply, the enable pin and the gate-driver supplies. Only when all of them agree does it leave shutdown. It then waits a fixed number of switching periods. After that it raises a reference code for the regulation DAC by one step per switching period, up to a programmed target.

The PWM outputs stay in the high-impedance state through shutdown, through the delay and through the early part of the ramp. They are released only once the rising reference has caught up with the output voltage that is already present. This means a pre-charged output is never pulled down. Power-good follows once the ramp has finished and the output sits inside its window. If any readiness input drops, everything falls straight back to shutdown.

Top module: `ss_sequencer`

## Requirements
- R1: The block leaves shutdown only when `bias_ok`, `en_hi` and `drv_ok[0]` are all high in the same cycle.
- R2: When `phase_sel` is 2 or 3, `drv_ok[1]` and `drv_ok[2]` must also be high. When `phase_sel` is 0 or 1, both are ignored.
- R3: In reset and in shutdown, `ref_code` is 0, `pwm_hiz` is all ones and `pgood` is 0.
- R4: Take the first rising edge at which the enable condition holds. After it, 64 edges with `sw_tick` high form the delay. The next tick edge then starts the ramp. With `sw_tick` held high, `ref_code` first becomes 1 on the 66th rising edge counted from that first edge, and is 0 before it.
- R5: During shutdown and the delay, `pwm_hiz` stays all ones whatever `out_reached` does. Once `out_reached` is seen high while ramping, the used phases are released on the next edge. They stay released until shutdown, even if `out_reached` falls.
- R6: While ramping, each edge with `sw_tick` high moves `ref_code` one LSB toward `target_code`. If `ref_code` is above `target_code`, it is set to `target_code` instead. An edge without `sw_tick` leaves `ref_code` unchanged. `ref_code` never exceeds the target after a tick.
- R7: `pgood` is high exactly when the block is ramping, `ref_code` equals `target_code`, and `in_window` is high.
- R8: If the enable condition drops during the delay or the ramp, then on the next edge `ref_code` is 0, `pwm_hiz` is all ones and `pgood` is 0. A later restart repeats the full delay.
- R9: Bit i of `pwm_hiz` controls phase i+1, and 1 means tristate. A `phase_sel` of 0 or 1 uses phase 1, 2 uses phases 1 and 2, and 3 uses all three. Unused phases always read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bias_ok | input | 1 | Bias supply above its power-on level |
| en_hi | input | 1 | Enable pin above its threshold |
| drv_ok | input | 3 | Per-phase driver supply above its power-on level |
| phase_sel | input | 2 | Number of active phases (0 or 1, 2, 3) |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| target_code | input | 8 | Programmed reference level |
| out_reached | input | 1 | Reference has reached the sensed output level |
| in_window | input | 1 | Output inside its regulation window |
| ref_code | output | 8 | Reference code for the regulation DAC |
| pwm_hiz | output | 3 | Per-phase tristate control, 1 = high impedance |
| pgood | output | 1 | Power-good |

## Verification
The bench sweeps every combination of the five readiness inputs under each phase setting. A gate that ignores the extra driver supplies in multiphase mode, or demands them in single-phase mode, shows up as a ramp that starts or stays at zero when it should not. The edge just before and the edge just after the 64-period delay are both checked, so an off-by-one counter moves the first step and is caught. Release is tried with `out_reached` high during the delay and low after release: a design that releases early, or that re-tristates, breaks the expected `pwm_hiz` pattern. Saturation, lowering the target, missing ticks and dropping enable mid-ramp each show up as a wrong `ref_code` or a stale `pgood`.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_RAMP = 2'd2
  } sq_state_t;

  // number of phases in use for a phase-select value (0 reads as one phase)
  function automatic logic [1:0] used_phases(input logic [1:0] sel);
    return (sel == 2'd0) ? 2'd1 : sel;
  endfunction

  // multiphase operation needs every driver supply, not just the first
  function automatic logic needs_all_drv(input logic [1:0] sel);
    return sel >= 2'd2;
  endfunction

endpackage

// File: rtl/ss_enable_gate.sv
module ss_enable_gate
  import ss_seq_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           bias_ok,
  input  logic           en_hi,
  input  logic [NPH-1:0] drv_ok,
  input  logic [1:0]     phase_sel,
  output logic           en_all
);

  logic first_ok;
  logic rest_ok;

  assign first_ok = bias_ok & en_hi & drv_ok[0];
  assign rest_ok  = !needs_all_drv(phase_sel) || (&drv_ok[NPH-1:1]);
  assign en_all   = first_ok & rest_ok;

endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int CODE_W    = 8,
  parameter int DELAY_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_on,
  input  logic              ramp_on,
  input  logic              sw_tick,
  input  logic [CODE_W-1:0] target,
  output logic              delay_done,
  output logic [CODE_W-1:0] ref_code
);

  localparam int CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYC - 1);

  logic [CNT_W-1:0] dly_cnt;

  // one LSB toward the target, clamping straight to it from above
  function automatic logic [CODE_W-1:0] next_code(input logic [CODE_W-1:0] cur,
                                                  input logic [CODE_W-1:0] tgt);
    return (cur < tgt) ? cur + CODE_W'(1) : tgt;
  endfunction

  assign delay_done = wait_on && sw_tick && (dly_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !wait_on) begin
      dly_cnt <= '0;
    end else if (sw_tick) begin
      dly_cnt <= dly_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ramp_on) begin
      ref_code <= '0;
    end else if (sw_tick) begin
      ref_code <= next_code(ref_code, target);
    end
  end

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_on && sw_tick && ref_code < target) |=>
      (ref_code == $past(ref_code) + CODE_W'(1)) || (ref_code == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_on && !sw_tick) |=> ($stable(ref_code) || ref_code == '0));

  p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_on && sw_tick) |=> (ref_code <= $past(target)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_on |=> (ref_code == '0));

endmodule

// File: rtl/ss_phase_ctl.sv
module ss_phase_ctl
  import ss_seq_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ramp_on,
  input  logic           out_reached,
  input  logic [1:0]     phase_sel,
  output logic           released,
  output logic [NPH-1:0] pwm_hiz
);

  logic [1:0] nph;

  assign nph = used_phases(phase_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      released <= 1'b0;
    end else begin
      released <= ramp_on && (released || out_reached);
    end
  end

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    assign pwm_hiz[i] = !(released && (2'(i) < nph));

    p_unused_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (2'(i) >= nph) |-> pwm_hiz[i]);
  end

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (released && ramp_on) |=> (released || !ramp_on));

  p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_on && !released) |=> !released);

endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer
  import ss_seq_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int DELAY_CYC = 64,
  parameter int NPH       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bias_ok,
  input  logic              en_hi,
  input  logic [NPH-1:0]    drv_ok,
  input  logic [1:0]        phase_sel,
  input  logic              sw_tick,
  input  logic [CODE_W-1:0] target_code,
  input  logic              out_reached,
  input  logic              in_window,
  output logic [CODE_W-1:0] ref_code,
  output logic [NPH-1:0]    pwm_hiz,
  output logic              pgood
);

  sq_state_t st;
  logic      en_all;
  logic      delay_done;
  logic      wait_on;
  logic      ramp_on;
  logic      released;

  ss_enable_gate #(.NPH(NPH)) i_gate (
    .bias_ok   (bias_ok),
    .en_hi     (en_hi),
    .drv_ok    (drv_ok),
    .phase_sel (phase_sel),
    .en_all    (en_all)
  );

  assign wait_on = (st == SQ_WAIT) && en_all;
  assign ramp_on = (st == SQ_RAMP) && en_all;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_all) begin
      st <= SQ_OFF;
    end else begin
      case (st)
        SQ_OFF:  st <= SQ_WAIT;
        SQ_WAIT: st <= delay_done ? SQ_RAMP : SQ_WAIT;
        default: st <= SQ_RAMP;
      endcase
    end
  end

  ss_ramp #(.CODE_W(CODE_W), .DELAY_CYC(DELAY_CYC)) i_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_on    (wait_on),
    .ramp_on    (ramp_on),
    .sw_tick    (sw_tick),
    .target     (target_code),
    .delay_done (delay_done),
    .ref_code   (ref_code)
  );

  ss_phase_ctl #(.NPH(NPH)) i_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .ramp_on     (ramp_on),
    .out_reached (out_reached),
    .phase_sel   (phase_sel),
    .released    (released),
    .pwm_hiz     (pwm_hiz)
  );

  assign pgood = (st == SQ_RAMP) && (ref_code == target_code) && in_window;

  p_shut_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_OFF) |-> (&pwm_hiz && !pgood && ref_code == '0));

  p_stay_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_OFF && !en_all) |=> (st == SQ_OFF));

  p_drop_pgood_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_all |=> (!pgood && &pwm_hiz));

  p_pgood_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> in_window);

endmodule

// File: tb/test_ss_sequencer.sv
module test_ss_sequencer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bias_ok, en_hi;
  logic [2:0] drv_ok;
  logic [1:0] phase_sel;
  logic       sw_tick;
  logic [7:0] target_code;
  logic       out_reached, in_window;
  logic [7:0] ref_code;
  logic [2:0] pwm_hiz;
  logic       pgood;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ss_sequencer i_ss_sequencer (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .en_hi(en_hi), .drv_ok(drv_ok),
    .phase_sel(phase_sel), .sw_tick(sw_tick), .target_code(target_code),
    .out_reached(out_reached), .in_window(in_window),
    .ref_code(ref_code), .pwm_hiz(pwm_hiz), .pgood(pgood)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_enable(input logic [4:0] v, input logic [1:0] ps);
    return v[0] & v[1] & v[2] & ((ps < 2) || (v[3] & v[4]));
  endfunction

  function automatic logic [2:0] exp_hiz(input logic [1:0] ps);
    case (ps)
      2'd2:    return 3'b100;
      2'd3:    return 3'b000;
      default: return 3'b110;
    endcase
  endfunction

  task automatic all_on(input logic [1:0] ps);
    phase_sel = ps; bias_ok = 1; en_hi = 1; drv_ok = 3'b111;
  endtask

  task automatic go_off();
    bias_ok = 0; step(2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bias_ok = 0; en_hi = 0; drv_ok = 0; phase_sel = 1; sw_tick = 1;
    target_code = 2; out_reached = 0; in_window = 0;
    #1; step(3);
    chk("R3 reset ref", ref_code, 0);
    chk("R3 reset hiz", pwm_hiz, 7);
    chk("R3 reset pgood", pgood, 0);
    rst_n = 1;
    all_on(1); in_window = 1; step(1);
    chk("R3 off ref", ref_code, 0);
    rst_n = 0; step(1); rst_n = 1;

    // enable sweep: R1 single phase, R2 multiphase
    for (int ps = 0; ps < 4; ps++) begin
      for (int v = 0; v < 32; v++) begin
        logic [4:0] vv;
        vv = 5'(v);
        go_off();
        phase_sel = 2'(ps);
        bias_ok = vv[0]; en_hi = vv[1]; drv_ok = vv[4:2];
        step(66);
        chk((ps < 2) ? "R1 gate" : "R2 gate", ref_code,
            exp_enable(vv, 2'(ps)) ? 1 : 0);
        chk("R3 hiz held", pwm_hiz, 7);
      end
    end

    // R4 delay boundary, R5 no release during delay
    go_off(); target_code = 5; in_window = 0; out_reached = 1;
    all_on(3); step(10);
    chk("R5 hiz in delay", pwm_hiz, 7);
    step(55);
    chk("R4 before step", ref_code, 0);
    chk("R5 hiz at ramp start", pwm_hiz, 7);
    step(1);
    chk("R4 first step", ref_code, 1);
    chk("R5 released", pwm_hiz, 0);
    out_reached = 0; step(3);
    chk("R5 sticky", pwm_hiz, 0);
    chk("R6 ramp", ref_code, 4);
    step(10);
    chk("R6 saturate", ref_code, 5);
    chk("R7 pgood no window", pgood, 0);
    in_window = 1; #1;
    chk("R7 pgood", pgood, 1);
    sw_tick = 0; target_code = 9; #1;
    chk("R7 off target", pgood, 0);
    step(4);
    chk("R6 no tick", ref_code, 5);
    sw_tick = 1; step(1);
    chk("R6 tick", ref_code, 6);
    target_code = 3; step(1);
    chk("R6 clamp", ref_code, 3);
    chk("R7 pgood clamp", pgood, 1);

    // R8 drop mid-ramp
    en_hi = 0; step(1);
    chk("R8 ref", ref_code, 0);
    chk("R8 hiz", pwm_hiz, 7);
    chk("R8 pgood", pgood, 0);
    en_hi = 1; step(65);
    chk("R8 restart delay", ref_code, 0);
    step(1);
    chk("R8 restart step", ref_code, 1);

    // R8 drop during delay
    go_off(); all_on(1); step(30);
    drv_ok[0] = 0; step(1); drv_ok[0] = 1; step(65);
    chk("R8 delay drop", ref_code, 0);

    // R9 phase masks, R5 release only after out_reached
    for (int ps = 0; ps < 4; ps++) begin
      go_off(); out_reached = 0; target_code = 2;
      all_on(2'(ps)); step(70);
      chk("R5 wait for reach", pwm_hiz, 7);
      out_reached = 1; step(1);
      chk("R9 mask", pwm_hiz, exp_hiz(2'(ps)));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule